// File: doc/BRIEF.md
# Periodic Interrupt Timer

This block raises an interrupt request at a fixed, software-chosen interval. A control byte sets the interval as a multiplier of one of two time units: a short unit of 8.192 ms or a long unit of 131.072 ms, sixteen short units. Each expiry raises one request on a priority line picked by a 3-bit level code. The request stays raised until the interrupt handler acknowledges it. On that acknowledge the block returns a vector byte that software has loaded.

The time base comes from a prescaler sized by the `CLK_HZ` parameter. One prescaler wrap lasts one short unit, `TICK_CYC = CLK_HZ*8192/1000000` clock cycles, with a minimum of 1. A small `CLK_HZ` gives a short time base for simulation. Bus arbitration and acknowledge handshakes lie outside the block. Acknowledge arrives as a single-cycle strobe.

Top module: `pit_timer`

## Requirements
- R1: Writing the control byte stores bit 7 as the enable, bit 6 as the unit select (0 = short, 1 = long) and bits 2:0 as the multiplier m. `ctrl_q` reads these back with bits 5:3 always 0.
- R2: The short unit lasts TICK_CYC clock cycles and the long unit lasts 16×TICK_CYC cycles.
- R3: A control write with enable set starts a period of N = (m+1)×unit cycles. The request appears N cycles after the write edge, and further expiries follow every N cycles while the block stays enabled.
- R4: The vector register is written from `wdata` when `vec_wr` is high. It reads back on `vec_q` and is 0 after reset.
- R5: When a request is pending and the level code c is in 1..7, only `irq_req[c-1]` is high. With code 0 no line is driven, and an expiry while the code is 0 leaves nothing pending.
- R6: A pending request holds until it is acknowledged. Further expiries while it is pending do not queue a second request.
- R7: An `iack` strobe while a request is pending drops the request at the next edge. In the following cycle `ack_vld` is high for one cycle and `ack_vec` carries the vector. `iack` with nothing pending has no effect, and `ack_vec` is 0 whenever `ack_vld` is low.
- R8: Every control write restarts the period count from zero.
- R9: Clearing the enable stops and zeroes the count. It does not drop a request that is already pending.
- R10: A synchronous active-low reset clears the control byte, the vector, the count, the pending request and the acknowledge outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Write strobe for the control byte |
| vec_wr | input | 1 | Write strobe for the vector byte |
| wdata | input | 8 | Write data |
| level_code | input | 3 | Request level select, 0 = none |
| iack | input | 1 | Interrupt acknowledge strobe |
| ctrl_q | output | 8 | Control byte readback |
| vec_q | output | 8 | Vector byte readback |
| irq_req | output | 7 | Request lines, bit c-1 for level c |
| ack_vld | output | 1 | Vector valid, one cycle after an accepted acknowledge |
| ack_vec | output | 8 | Vector returned on acknowledge |

## Verification
The bench builds the block with `CLK_HZ = 1000`, which makes TICK_CYC equal to 8 cycles. The shortest period is then 8 cycles and the longest, multiplier 7 with the long unit, is 1024 cycles. Every period setting, including the full 16× long unit, can then be reached within a short run. The behavioural model counts cycles since the last restart as a plain integer. It shows where restarts, disables and acknowledges fall against expiries, and whether a second expiry is ever queued.

// File: rtl/pit_pkg.sv
// Shared constants for the periodic interrupt timer.
// Assumes an 8-bit control byte with fixed field positions.
package pit_pkg;
    localparam int CTL_W       = 8;   // control byte width
    localparam int CTL_EN_BIT  = 7;   // enable field
    localparam int CTL_UNIT_BIT = 6;  // unit select field
    localparam int MULT_W      = 3;   // multiplier field, bits MULT_W-1:0
    localparam int LVL_W       = 3;   // level code width
    localparam int LVL_N       = 7;   // number of request lines
    localparam int UNIT_RATIO  = 16;  // long unit / short unit
    localparam longint SHORT_UNIT_NS_X1000 = 64'd8192; // short unit in units of 1/1e6 s * 1000
endpackage

// File: rtl/pit_prescaler.sv
// Prescaler: divides the clock into one tick per short time unit.
// Assumes restart and run come from the control register; a restart or
// an idle (run low) holds the count at zero.
module pit_prescaler #(
    parameter int TICK_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int CW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYC - 1);

    logic [CW-1:0] cnt;

    // Purpose: count clock cycles within one short unit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Purpose: flag the last cycle of each short unit.
    always_comb begin
        tick = run && !restart && (cnt == LAST);
    end

    a_r8_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));
endmodule

// File: rtl/pit_period.sv
// Period counter: counts short-unit ticks into units (1 or UNIT_RATIO
// ticks each), then units into (mult+1), and pulses expire on the last one.
// Assumes unit select and mult only change together with a restart.
module pit_period #(
    parameter int UNIT_RATIO = 16,
    parameter int MULT_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic              tick,
    input  logic              long_unit,
    input  logic [MULT_W-1:0] mult,
    output logic              expire
);
    localparam int UW = (UNIT_RATIO > 1) ? $clog2(UNIT_RATIO) : 1;

    logic [UW-1:0]     unit_cnt;
    logic [MULT_W-1:0] mult_cnt;
    logic [UW-1:0]     unit_last;
    logic              unit_done;

    // Purpose: decode the end of the current unit and of the period.
    always_comb begin
        unit_last = long_unit ? UW'(UNIT_RATIO - 1) : '0;
        unit_done = tick && (unit_cnt == unit_last);
        expire    = unit_done && (mult_cnt == mult);
    end

    // Purpose: advance the unit and multiplier counters on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            unit_cnt <= '0;
            mult_cnt <= '0;
        end else if (tick) begin
            if (unit_done) begin
                unit_cnt <= '0;
                mult_cnt <= expire ? '0 : mult_cnt + 1'b1;
            end else begin
                unit_cnt <= unit_cnt + 1'b1;
            end
        end
    end

    a_r3_mult_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart) |=> (mult_cnt <= mult));
endmodule

// File: rtl/pit_router.sv
// Router: drives the pending request onto the line picked by the level
// code; code 0 selects no line. Purely combinational.
module pit_router #(
    parameter int LVL_W = 3,
    parameter int LVL_N = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic             pending,
    output logic [LVL_N-1:0] irq_req
);
    // Purpose: one comparator per request line.
    for (genvar i = 0; i < LVL_N; i++) begin : g_line
        assign irq_req[i] = pending && (level == LVL_W'(i + 1));
    end

    a_r5_one_line: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_req));
    a_r5_no_line_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |-> (irq_req == '0));
endmodule

// File: rtl/pit_timer.sv
// Periodic interrupt timer top: control and vector registers, pending
// request and acknowledge path. Assumes iack is a one-cycle strobe and
// level_code is a static strap-like input.
module pit_timer
    import pit_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             vec_wr,
    input  logic [7:0]       wdata,
    input  logic [2:0]       level_code,
    input  logic             iack,
    output logic [7:0]       ctrl_q,
    output logic [7:0]       vec_q,
    output logic [6:0]       irq_req,
    output logic             ack_vld,
    output logic [7:0]       ack_vec
);
    localparam longint TICK_RAW = (64'(CLK_HZ) * SHORT_UNIT_NS_X1000) / 64'd1000000;
    localparam int     TICK_CYC = (TICK_RAW < 64'd1) ? 1 : int'(TICK_RAW);

    logic              en_q;
    logic              unit_q;
    logic [MULT_W-1:0] mult_q;
    logic              pend_q;
    logic              tick;
    logic              expire;
    logic              take;

    // Purpose: hold the control fields; reserved bits are not stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            unit_q <= 1'b0;
            mult_q <= '0;
        end else if (ctrl_wr) begin
            en_q   <= wdata[CTL_EN_BIT];
            unit_q <= wdata[CTL_UNIT_BIT];
            mult_q <= wdata[MULT_W-1:0];
        end
    end

    // Purpose: hold the vector byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (vec_wr) begin
            vec_q <= wdata;
        end
    end

    // Purpose: readback view of the control byte.
    always_comb begin
        ctrl_q = '0;
        ctrl_q[CTL_EN_BIT]   = en_q;
        ctrl_q[CTL_UNIT_BIT] = unit_q;
        ctrl_q[MULT_W-1:0]   = mult_q;
    end

    pit_prescaler #(.TICK_CYC(TICK_CYC)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(en_q), .restart(ctrl_wr), .tick(tick)
    );

    pit_period #(.UNIT_RATIO(UNIT_RATIO), .MULT_W(MULT_W)) u_per (
        .clk(clk), .rst_n(rst_n), .run(en_q), .restart(ctrl_wr), .tick(tick),
        .long_unit(unit_q), .mult(mult_q), .expire(expire)
    );

    // Purpose: an expiry counts only when a level is selected.
    always_comb begin
        take = expire && (level_code != '0);
    end

    // Purpose: pending request, set by expiry, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (take) begin
            pend_q <= 1'b1;
        end else if (iack) begin
            pend_q <= 1'b0;
        end
    end

    // Purpose: return the vector one cycle after an accepted acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_vld <= 1'b0;
            ack_vec <= '0;
        end else begin
            ack_vld <= iack && pend_q;
            ack_vec <= (iack && pend_q) ? vec_q : '0;
        end
    end

    pit_router #(.LVL_W(LVL_W), .LVL_N(LVL_N)) u_rte (
        .clk(clk), .rst_n(rst_n), .level(level_code), .pending(pend_q), .irq_req(irq_req)
    );

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !iack) |=> pend_q);
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && iack && !take) |=> !pend_q);
    a_r7_ack_source: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld |-> $past(pend_q && iack));
    a_r4_vec_write: assert property (@(posedge clk) disable iff (!rst_n)
        vec_wr |=> (vec_q == $past(wdata)));
endmodule

// File: tb/pit_timer_test.sv
module pit_timer_test;
    localparam int CLK_HZ = 1000;
    localparam int TICK   = (CLK_HZ * 8192) / 1000000; // 8 cycles per short unit

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 1'b0, vec_wr = 1'b0, iack = 1'b0;
    logic [7:0] wdata = '0;
    logic [2:0] level_code = '0;
    logic [7:0] ctrl_q, vec_q, ack_vec;
    logic [6:0] irq_req;
    logic       ack_vld;

    int checks = 0, errors = 0;
    bit finished = 0;

    pit_timer #(.CLK_HZ(CLK_HZ)) uut (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .vec_wr(vec_wr), .wdata(wdata),
        .level_code(level_code), .iack(iack), .ctrl_q(ctrl_q), .vec_q(vec_q),
        .irq_req(irq_req), .ack_vld(ack_vld), .ack_vec(ack_vec)
    );

    always #2.5 clk = ~clk;

    // Reference model state
    bit   m_en, m_unit, m_pend, m_ackv, m_exp;
    int   m_mult, m_cnt;
    logic [7:0] m_vec, m_ackvec;

    function automatic int period_len();
        return TICK * (m_unit ? 16 : 1) * (m_mult + 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_unit = 0; m_mult = 0; m_cnt = 0; m_pend = 0;
            m_vec = '0; m_ackv = 0; m_ackvec = '0;
        end else begin
            m_exp = 0;
            if (ctrl_wr) m_cnt = 0;
            else if (m_en) begin
                if (m_cnt == period_len() - 1) begin m_exp = 1; m_cnt = 0; end
                else m_cnt++;
            end else m_cnt = 0;
            m_ackv   = iack && m_pend;
            m_ackvec = m_ackv ? m_vec : 8'h00;
            if (m_exp && level_code != 0) m_pend = 1;
            else if (iack) m_pend = 0;
            if (ctrl_wr) begin m_en = wdata[7]; m_unit = wdata[6]; m_mult = wdata[2:0]; end
            if (vec_wr) m_vec = wdata;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [6:0] exp_irq();
        if (m_pend && level_code != 0) return 7'(1) << (level_code - 1);
        return 7'b0;
    endfunction

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(irq_req == exp_irq(), "R5/R6 irq_req", 32'(irq_req), 32'(exp_irq()));
            check(ack_vld == m_ackv, "R7 ack_vld", 32'(ack_vld), 32'(m_ackv));
            check(ack_vec == m_ackvec, "R7 ack_vec", 32'(ack_vec), 32'(m_ackvec));
            check(ctrl_q == {m_en, m_unit, 3'b000, 3'(m_mult)}, "R1 ctrl_q",
                  32'(ctrl_q), 32'({m_en, m_unit, 3'b000, 3'(m_mult)}));
            check(vec_q == m_vec, "R4 vec_q", 32'(vec_q), 32'(m_vec));
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        ctrl_wr = 1'b1; wdata = v;
        step(1);
        ctrl_wr = 1'b0; wdata = '0;
    endtask

    task automatic wr_vec(input logic [7:0] v);
        vec_wr = 1'b1; wdata = v;
        step(1);
        vec_wr = 1'b0; wdata = '0;
    endtask

    task automatic ack();
        iack = 1'b1;
        step(1);
        iack = 1'b0;
    endtask

    // Checks the request edge: low at N-1 cycles after the write edge, high at N.
    task automatic period_edge(input int n, input string tag);
        step(n - 1);
        check(irq_req == 7'b0, tag, 32'(irq_req), 0);
        step(1);
        check(irq_req != 7'b0, tag, 32'(irq_req), 1);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(3);
        // R10: reset state
        check(ctrl_q == 0 && vec_q == 0 && irq_req == 0 && !ack_vld, "R10 reset state",
              {ctrl_q, vec_q, 1'b0, irq_req, 7'b0, ack_vld}, 0);
        rst_n = 1'b1;
        step(1);

        // R4: vector write
        wr_vec(8'hA5);
        check(vec_q == 8'hA5, "R4 vector readback", 32'(vec_q), 32'hA5);

        // R1: reserved bits read zero; R3/R2: short period with m=0
        level_code = 3'd3;
        wr_ctrl(8'hB8);
        check(ctrl_q == 8'h80, "R1 reserved bits zero", 32'(ctrl_q), 32'h80);
        period_edge(TICK, "R3 R2 short period m=0");
        check(irq_req == 7'b0000100, "R5 level 3 line", 32'(irq_req), 32'h04);

        // R6: held across later expiries, no queueing; R8 restart realigns
        wr_ctrl(8'h80);
        step(3 * TICK + 2);
        check(irq_req == 7'b0000100, "R6 held until ack", 32'(irq_req), 32'h04);
        ack();
        check(ack_vld && ack_vec == 8'hA5, "R7 ack returns vector", 32'({ack_vld, ack_vec}), 32'h1A5);
        check(irq_req == 7'b0, "R6 no queued request", 32'(irq_req), 0);
        step(1);
        check(!ack_vld, "R7 ack one cycle", 32'(ack_vld), 0);

        // R7: acknowledge with nothing pending
        ack();
        check(!ack_vld && ack_vec == 0, "R7 ack without pending", 32'({ack_vld, ack_vec}), 0);

        // R2/R3: longest period, long unit, m=7
        wr_ctrl(8'hC7);
        period_edge(TICK * 16 * 8, "R2 R3 long unit m=7");
        ack();

        // R8: restart mid-period
        wr_ctrl(8'h81);
        step(10);
        wr_ctrl(8'h81);
        period_edge(TICK * 2, "R8 restart from zero");
        ack();

        // R5: level code 0 drives nothing and leaves nothing pending
        level_code = 3'd0;
        wr_ctrl(8'h80);
        step(3 * TICK + 1);
        check(irq_req == 7'b0, "R5 code 0 no line", 32'(irq_req), 0);
        level_code = 3'd7;
        step(1);
        check(irq_req == 7'b0, "R5 code 0 nothing pending", 32'(irq_req), 0);
        step(TICK);
        check(irq_req == 7'b1000000, "R5 level 7 line", 32'(irq_req), 32'h40);
        ack();

        // R9: disable stops counting but keeps the pending request
        level_code = 3'd2;
        wr_ctrl(8'h80);
        period_edge(TICK, "R3 period level 2");
        wr_ctrl(8'h00);
        step(2 * TICK);
        check(irq_req == 7'b0000010, "R9 pending kept when disabled", 32'(irq_req), 32'h02);
        ack();
        step(4 * TICK);
        check(irq_req == 7'b0, "R9 no expiry when disabled", 32'(irq_req), 0);

        // R10: reset during operation
        wr_vec(8'h3C);
        wr_ctrl(8'h80);
        step(TICK + 1);
        rst_n = 1'b0;
        step(1);
        check(irq_req == 0 && ctrl_q == 0 && vec_q == 0, "R10 reset mid-run",
              {ctrl_q, vec_q, 1'b0, irq_req}, 0);
        rst_n = 1'b1;
        step(2 * TICK);
        check(irq_req == 0, "R10 no request after reset", 32'(irq_req), 0);

        finish_run();
    end
endmodule